// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents two active-low processor interrupt lines: a fast line and a normal line. Software programs each source with a priority level from 0 to 7, an input sensitivity and an enable bit. Every cycle the block picks one winner among the pending, enabled sources that are not masked by nesting. It compares level first and channel number second. A winner at level 0 drives the fast line, and any other winner drives the normal line.

The processor's handler reads a current-interrupt register over APB. That read acknowledges the winner and returns its channel and level. It also pushes the level onto a hardware in-service stack, which masks every request at that level or a lower-priority level. A write to an end-of-service register pops the stack and lifts the mask. Edge-sensitive sources latch a pending flag, and the acknowledge clears that flag. Level-sensitive sources follow their input.

Top module: `pvic_top`

## Requirements
- R1: After a synchronous reset, every source is disabled, at level 7, high-level sensitive, and both `fiq_n` and `irq_n` are high.
- R2: A pending, enabled source at a numerically lower level beats every source at a higher level.
- R3: Among eligible sources at the same level, the lowest channel number wins.
- R4: A winner at level 0 drives `fiq_n` low and a winner at levels 1 to 7 drives `irq_n` low; the two lines are never low together.
- R5: The per-source configuration word at byte offset 4×channel holds the level in bits [2:0] and the sensitivity in bits [5:4]: 00 high level, 01 low level, 10 rising edge, 11 falling edge.
- R6: The enable register (offset 0x100, one bit per channel) gates arbitration; a disabled source never drives an output, while the raw input (0x104) and pending flags (0x108) stay readable regardless of enable.
- R7: Reading offset 0x10C returns bit 31 = a winner exists, bits [10:8] = its level, bits [4:0] = its channel, and acknowledges that winner.
- R8: While an acknowledged interrupt is in service, sources at the same or a numerically higher level are masked; a strictly more urgent source, including a level-0 fast request, still asserts its line.
- R9: A write to offset 0x118 ends the most recent service and restores the previous mask; such a write with nothing in service has no effect.
- R10: An edge-sensitive source's pending flag is cleared by hardware when that source is acknowledged.
- R11: A request input passes through two synchronizer flops and a pending stage; an output line changes on the fourth rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC | Asynchronous request lines, one per channel |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| fiq_n | output | 1 | Fast interrupt, active low, registered |
| irq_n | output | 1 | Normal interrupt, active low, registered |

## Verification
The bench builds the block with its defaults of 32 channels and 8 levels. At that size it can reach channel 31, the level-0 fast path and the level-7 floor in the same run. Nested acknowledges drive the in-service stack three entries deep. The test lets a fast request preempt two stacked normal services and then unwinds them one at a time. At each pop it checks the point where a previously masked same-level source wins again.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {
    SENS_HIGH = 2'b00,
    SENS_LOW  = 2'b01,
    SENS_RISE = 2'b10,
    SENS_FALL = 2'b11
  } sense_e;

  // word indices of the control registers (byte offset / 4)
  localparam int REG_ENABLE = 64;
  localparam int REG_RAW    = 65;
  localparam int REG_PEND   = 66;
  localparam int REG_CUR    = 67;
  localparam int REG_EOS    = 70;

  function automatic logic sense_is_edge(sense_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/pvic_src.sv
module pvic_src
  import pvic_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_in,
  input  sense_e sense,
  input  logic   take,
  output logic   sync_o,
  output logic   pend_o
);
  logic s1_q, s2_q, prev_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= req_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      unique case (sense)
        SENS_HIGH: pend_q <= s2_q;
        SENS_LOW:  pend_q <= ~s2_q;
        SENS_RISE: begin
          if (take)               pend_q <= 1'b0;
          else if (s2_q & ~prev_q) pend_q <= 1'b1;
        end
        SENS_FALL: begin
          if (take)               pend_q <= 1'b0;
          else if (~s2_q & prev_q) pend_q <= 1'b1;
        end
        default: pend_q <= 1'b0;
      endcase
    end
  end

  assign sync_o = s2_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int NSRC = 32,
  parameter int NLVL = 8,
  localparam int CW = $clog2(NSRC),
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NSRC-1:0]         pend,
  input  logic [NSRC-1:0]         en,
  input  logic [NSRC-1:0][LW-1:0] lvl,
  input  logic [LW:0]             thr,
  output logic                    valid,
  output logic [CW-1:0]           ch,
  output logic [LW-1:0]           lvl_o
);
  logic [NSRC-1:0] elig;
  logic [NLVL-1:0] hit;
  logic [LW-1:0]   best;

  // stage 0: nesting mask
  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = pend[i] & en[i] & ({1'b0, lvl[i]} < thr);
  end

  // stage 1: most urgent populated level
  always_comb begin
    hit  = '0;
    best = '0;
    for (int l = 0; l < NLVL; l++)
      for (int i = 0; i < NSRC; i++)
        if (elig[i] && lvl[i] == LW'(l)) hit[l] = 1'b1;
    for (int l = NLVL - 1; l >= 0; l--)
      if (hit[l]) best = LW'(l);
  end

  // stage 2: lowest channel within that level
  always_comb begin
    ch = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i] && lvl[i] == best) ch = CW'(i);
  end

  assign valid = |hit;
  assign lvl_o = best;
endmodule

// File: rtl/pvic_stack.sv
module pvic_stack #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW:0]   thr
);
  localparam logic [LW:0] DEPTH = (LW + 1)'(NLVL);

  logic [LW-1:0] mem [NLVL];
  logic [LW:0]   ptr_q;
  logic [LW:0]   ptr_m1;

  assign ptr_m1 = ptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (push && ptr_q < DEPTH) mem[ptr_q[LW-1:0]] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (push) begin
      if (ptr_q < DEPTH) ptr_q <= ptr_q + 1'b1;
    end else if (pop && ptr_q != '0) ptr_q <= ptr_m1;
  end

  assign thr = (ptr_q == '0) ? DEPTH : {1'b0, mem[ptr_m1[LW-1:0]]};
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NLVL = 8,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_src,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [DW-1:0]   pwdata,
  output logic [DW-1:0]   prdata,
  output logic            fiq_n,
  output logic            irq_n
);
  localparam int CW = $clog2(NSRC);
  localparam int LW = $clog2(NLVL);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_NSRC = IW'(NSRC);
  localparam logic [IW-1:0] A_EN   = IW'(REG_ENABLE);
  localparam logic [IW-1:0] A_RAW  = IW'(REG_RAW);
  localparam logic [IW-1:0] A_PEND = IW'(REG_PEND);
  localparam logic [IW-1:0] A_CUR  = IW'(REG_CUR);
  localparam logic [IW-1:0] A_EOS  = IW'(REG_EOS);
  localparam logic [LW-1:0] LVL_FLOOR = LW'(NLVL - 1);

  logic [IW-1:0]           widx;
  logic                    wr, rd, cfg_hit, ack, eos;
  logic [NSRC-1:0]         en_q;
  logic [NSRC-1:0][LW-1:0] lvl_q;
  sense_e                  sen_q [NSRC];
  logic [NSRC-1:0]         edge_m, take, raw, pend;
  logic                    arb_v;
  logic [CW-1:0]           arb_ch;
  logic [LW-1:0]           arb_lvl;
  logic [LW:0]             thr;
  logic                    win_v_q;
  logic [CW-1:0]           win_ch_q;
  logic [LW-1:0]           win_lvl_q;
  logic                    unused_bits;

  assign unused_bits = ^{pwdata[DW-1:6], pwdata[3:LW], paddr[1:0]};
  assign widx    = paddr[AW-1:2];
  assign wr      = psel & penable & pwrite;
  assign rd      = psel & penable & ~pwrite;
  assign cfg_hit = widx < A_NSRC;
  assign ack     = rd && widx == A_CUR && win_v_q;
  assign eos     = wr && widx == A_EOS;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        lvl_q[i] <= LVL_FLOOR;
        sen_q[i] <= SENS_HIGH;
      end
    end else if (wr) begin
      if (widx == A_EN) en_q <= pwdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_hit && widx[CW-1:0] == CW'(i)) begin
          lvl_q[i] <= pwdata[LW-1:0];
          sen_q[i] <= sense_e'(pwdata[5:4]);
        end
      end
    end
  end

  // per-source conditioning
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign edge_m[g] = sense_is_edge(sen_q[g]);
    assign take[g]   = ack & edge_m[g] & (win_ch_q == CW'(g));
    pvic_src u_src (
      .clk    (clk),
      .rst    (rst),
      .req_in (irq_src[g]),
      .sense  (sen_q[g]),
      .take   (take[g]),
      .sync_o (raw[g]),
      .pend_o (pend[g])
    );
  end

  pvic_arb #(.NSRC(NSRC), .NLVL(NLVL)) u_arb (
    .pend  (pend),
    .en    (en_q),
    .lvl   (lvl_q),
    .thr   (thr),
    .valid (arb_v),
    .ch    (arb_ch),
    .lvl_o (arb_lvl)
  );

  pvic_stack #(.NLVL(NLVL)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ack),
    .push_lvl (win_lvl_q),
    .pop      (eos),
    .thr      (thr)
  );

  // registered winner and output lines
  always_ff @(posedge clk) begin
    if (rst) begin
      win_v_q   <= 1'b0;
      win_ch_q  <= '0;
      win_lvl_q <= '0;
      fiq_n     <= 1'b1;
      irq_n     <= 1'b1;
    end else begin
      win_v_q   <= arb_v;
      win_ch_q  <= arb_ch;
      win_lvl_q <= arb_lvl;
      fiq_n     <= ~(arb_v && arb_lvl == '0);
      irq_n     <= ~(arb_v && arb_lvl != '0);
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (cfg_hit) begin
      prdata[LW-1:0] = lvl_q[widx[CW-1:0]];
      prdata[5:4]    = sen_q[widx[CW-1:0]];
    end else begin
      case (widx)
        A_EN:   prdata[NSRC-1:0] = en_q;
        A_RAW:  prdata[NSRC-1:0] = raw;
        A_PEND: prdata[NSRC-1:0] = pend;
        A_CUR: begin
          prdata[DW-1]     = win_v_q;
          prdata[8 +: LW]  = win_lvl_q;
          prdata[CW-1:0]   = win_ch_q;
        end
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
  parameter int NSRC = 32,
  parameter int NLVL = 8,
  localparam int CW = $clog2(NSRC),
  localparam int LW = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst,
  input logic            fiq_n,
  input logic            irq_n,
  input logic            ack,
  input logic [NSRC-1:0] edge_m,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic [CW-1:0]   win_ch,
  input logic [LW:0]     thr
);
  logic            rst_d;
  logic [NSRC-1:0] en_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    en_d  <= en;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0)
      reset_idle_chk: assert (fiq_n && irq_n);
  end

  // R4
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fiq_n && !irq_n));

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!fiq_n || !irq_n) |-> en_d[win_ch]);

  // R8
  nest_tighten_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> thr < $past(thr));

  // R10
  edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && edge_m[win_ch]) |=> !pend[$past(win_ch)]);
endmodule

bind pvic_top pvic_checker #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .fiq_n  (fiq_n),
  .irq_n  (irq_n),
  .ack    (ack),
  .edge_m (edge_m),
  .pend   (pend),
  .en     (en_q),
  .win_ch (win_ch_q),
  .thr    (thr)
);

// File: tb/pvic_top_bench.sv
`timescale 1ns/1ps
module pvic_top_bench;
  localparam int NSRC = 32;
  localparam int AW   = 12;
  localparam int NV   = 6;
  // {chan_a, lvl_a, chan_b, lvl_b, expected chan, expect fast line}
  localparam int VEC [NV][6] = '{
    '{3, 5, 7, 2, 7, 0},
    '{3, 4, 1, 4, 1, 0},
    '{10, 0, 2, 1, 10, 1},
    '{20, 0, 5, 0, 5, 1},
    '{31, 7, 0, 7, 0, 0},
    '{31, 3, 30, 6, 31, 0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] irq_src = '0;
  logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]   paddr = '0;
  logic [31:0]     pwdata = '0;
  logic [31:0]     prdata;
  logic            fiq_n, irq_n;
  int              checks = 0;
  int              errors = 0;

  always #10 clk = ~clk;

  pvic_top u_pvic_top (
    .clk(clk), .rst(rst), .irq_src(irq_src), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic cfg(input int ch, input int lvl, input int sense);
    bus_wr(AW'(ch * 4), 32'((sense << 4) | lvl));
  endtask

  task automatic do_reset;
    rst = 1'b1; irq_src = '0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;

    // table walk: R2, R3, R4, R7
    for (int v = 0; v < NV; v++) begin
      do_reset;
      cfg(VEC[v][0], VEC[v][1], 0);
      cfg(VEC[v][2], VEC[v][3], 0);
      bus_wr(12'h100, (32'd1 << VEC[v][0]) | (32'd1 << VEC[v][2]));
      irq_src[VEC[v][0]] = 1'b1;
      irq_src[VEC[v][2]] = 1'b1;
      cycles(6);
      check("R4 lines", {30'd0, fiq_n, irq_n}, VEC[v][5] != 0 ? 32'h1 : 32'h2);
      bus_rd(12'h10C, d);
      check("R2 R3 R7 winner", {d[31], d[4:0]}, {1'b1, 5'(VEC[v][4])});
      irq_src = '0;
      bus_wr(12'h118, 0);
    end

    // R1 reset state
    do_reset;
    check("R1 lines", {fiq_n, irq_n}, 2'b11);
    bus_rd(12'h000, d);
    check("R1 cfg0", d, 32'h7);
    bus_rd(12'h100, d);
    check("R1 enable", d, 32'h0);

    // R6 disabled source: no output, raw and pending visible
    cfg(5, 1, 0);
    irq_src[5] = 1'b1;
    cycles(6);
    check("R6 masked line", {fiq_n, irq_n}, 2'b11);
    bus_rd(12'h104, d);
    check("R6 raw", d, 32'h20);
    bus_rd(12'h108, d);
    check("R6 pend", d, 32'h20);

    // R11 latency
    do_reset;
    cfg(6, 1, 0);
    bus_wr(12'h100, 32'h40);
    irq_src[6] = 1'b1;
    cycles(2);
    check("R11 early", irq_n, 1'b1);
    cycles(2);
    check("R11 on time", irq_n, 1'b0);

    // R5 low level sensitivity
    do_reset;
    cfg(14, 4, 1);
    bus_wr(12'h100, 32'h4000);
    cycles(6);
    check("R5 low level active", irq_n, 1'b0);
    irq_src[14] = 1'b1;
    cycles(6);
    check("R5 low level released", irq_n, 1'b1);

    // R5 rising edge and R10 auto clear
    do_reset;
    cfg(12, 2, 2);
    bus_wr(12'h100, 32'h1000);
    irq_src[12] = 1'b1;
    cycles(6);
    irq_src[12] = 1'b0;
    cycles(6);
    check("R5 rise latched", irq_n, 1'b0);
    bus_rd(12'h10C, d);
    check("R10 ack chan", d[4:0], 5'd12);
    cycles(2);
    bus_rd(12'h108, d);
    check("R10 pend cleared", d[12], 1'b0);
    check("R10 line released", irq_n, 1'b1);
    bus_wr(12'h118, 0);

    // R5 falling edge
    do_reset;
    cfg(13, 2, 3);
    bus_wr(12'h100, 32'h2000);
    irq_src[13] = 1'b1;
    cycles(6);
    check("R5 fall ignores rise", irq_n, 1'b1);
    irq_src[13] = 1'b0;
    cycles(6);
    check("R5 fall latched", irq_n, 1'b0);

    // R9 end-of-service with nothing in service is ignored
    do_reset;
    bus_wr(12'h118, 0);
    cfg(7, 3, 0);
    bus_wr(12'h100, 32'h80);
    irq_src[7] = 1'b1;
    cycles(6);
    check("R9 empty pop ignored", irq_n, 1'b0);

    // R8 nesting and fast preemption, R9 unwind
    do_reset;
    cfg(4, 3, 0); cfg(6, 5, 0); cfg(9, 3, 0); cfg(2, 1, 0); cfg(8, 0, 0);
    bus_wr(12'h100, 32'h354);
    irq_src[4] = 1'b1;
    cycles(6);
    bus_rd(12'h10C, d);
    check("R8 first ack", d[4:0], 5'd4);
    irq_src[6] = 1'b1; irq_src[9] = 1'b1;
    cycles(6);
    check("R8 same and lower masked", {fiq_n, irq_n}, 2'b11);
    irq_src[2] = 1'b1;
    cycles(6);
    check("R8 more urgent passes", irq_n, 1'b0);
    bus_rd(12'h10C, d);
    check("R8 second ack", {d[10:8], d[4:0]}, {3'd1, 5'd2});
    irq_src[8] = 1'b1;
    cycles(6);
    check("R8 fast preempts", {fiq_n, irq_n}, 2'b01);
    bus_rd(12'h10C, d);
    check("R8 fast ack", {d[10:8], d[4:0]}, {3'd0, 5'd8});
    irq_src[8] = 1'b0; irq_src[2] = 1'b0;
    bus_wr(12'h118, 0);
    cycles(6);
    check("R9 pop to level 1", {fiq_n, irq_n}, 2'b11);
    bus_wr(12'h118, 0);
    cycles(6);
    check("R9 pop to level 3", {fiq_n, irq_n}, 2'b11);
    bus_wr(12'h118, 0);
    cycles(6);
    check("R9 fully unwound", irq_n, 1'b0);
    bus_rd(12'h10C, d);
    check("R9 R3 rewin", d[4:0], 5'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule